// File: doc/BRIEF.md
# Four-Channel Reloadable Down-Counting Timer

This block holds four independent 32-bit timers behind a small synchronous register bus. Each channel counts down from a programmable reload value on every cycle where the shared `tick` strobe is high, provided both the block-wide run bit and the channel's own run bit are set. When a running channel sits at zero and a tick arrives, it reloads, bumps a 32-bit wrap tally and raises its event flag. Software that wants an up-counting time base reads the bitwise inverse of the count.

The live count is not visible directly. Reading a channel's wrap-tally register copies the live count into a capture register, and the count register returns that capture. A reader therefore fetches the tally first and the count second, and gets a pair that belongs to the same instant. The event flags of all channels, each gated by its own mask bit, are merged into one registered interrupt line.

Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.

Top module: `quad_down_timer`

## Requirements
- R1: After reset the block-wide run bit, channel run bits, counts, tallies, captures, event flags, mask bits and `irq` are 0, and every reload register reads 0xFFFFFFFF.
- R2: Register map (byte addresses): block control 0x00 (bit 0 = block run), revision 0x10 (read-only). Channel c occupies 0x20+0x20*c: +0x00 config (bit 0 = channel run), +0x04 reload, +0x08 count capture, +0x0C wrap tally, +0x10 event flag (bit 0), +0x14 flag clear (write-only), +0x18 mask (bit 0). Any other address, and a read of the flag-clear register, returns 0. Read data is valid one cycle after `rd_en`.
- R3: A channel's count moves only on a tick while both the block run bit and its own run bit are 1; otherwise it holds.
- R4: Writing channel run bit 1 while it is 0 loads the count from the reload register.
- R5: A tick on a running channel whose count is zero reloads the count and adds one to the wrap tally; any other counting tick subtracts one. After T ticks from a load with reload value V, the count is V - (T mod (V+1)) and the tally has risen by floor(T/(V+1)).
- R6: Reading the wrap-tally register captures the live count; reading the count register returns the latest capture, not the live count.
- R7: A wrap sets the channel's event flag; writing 1 in bit 0 of the flag-clear register clears it; when both happen in the same cycle the flag ends up set.
- R8: `irq` is, one cycle later, the OR over channels of event flag AND mask bit; a channel with mask 0 never drives it.
- R9: Writes to the count, tally, event-flag and revision registers change nothing.
- R10: Channels are independent: traffic and wraps on one channel leave the others' counts, tallies and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (has the capture side effect) |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest state to reach from the ports is a wrap tally that has advanced by a known amount on every channel at once, since the live count is only visible through the capture path and each read disturbs the capture. The bench freezes all channels by clearing the block run bit, then reads tally before count on each channel, and sweeps tick counts across several wrap periods with a different reload per channel so the arithmetic model separates them. The same-cycle collision of a wrap and a flag clear is forced by driving the tick and the clear write in one cycle on a channel with reload zero.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned OFS_W     = 5;
  localparam int unsigned CH_BASE   = 'h20;
  localparam int unsigned CH_STRIDE = 'h20;
  localparam int unsigned CTRL_ADDR = 'h00;
  localparam int unsigned REV_ADDR  = 'h10;

  typedef enum logic [OFS_W-1:0] {
    OFS_CFG  = 5'h00,
    OFS_RLD  = 5'h04,
    OFS_CNT  = 5'h08,
    OFS_OVF  = 5'h0C,
    OFS_STAT = 5'h10,
    OFS_CLR  = 5'h14,
    OFS_MASK = 5'h18
  } ch_ofs_e;
endpackage

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_run,
  input  logic          tick,
  input  logic          wr_cfg,
  input  logic          wr_rld,
  input  logic          wr_clr,
  input  logic          wr_msk,
  input  logic [DW-1:0] wdata,
  input  logic          rd_ovf,
  output logic          run_bit,
  output logic [DW-1:0] rld_val,
  output logic [DW-1:0] snap_val,
  output logic [DW-1:0] ovf_val,
  output logic          flag,
  output logic          mask,
  output logic          irq_req
);
  logic [DW-1:0] cnt_q, rld_q, snap_q, ovf_q;
  logic          en_q, st_q, msk_q;

  function automatic logic [DW-1:0] step_count(input logic [DW-1:0] c, input logic [DW-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  function automatic logic [DW-1:0] bump(input logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

  logic run, load_evt, at_zero, step_evt, wrap_evt, clr_evt;
  assign run      = glb_run & en_q;
  assign load_evt = wr_cfg & wdata[0] & ~en_q;
  assign at_zero  = (cnt_q == '0);
  assign step_evt = run & tick;
  assign wrap_evt = step_evt & at_zero;
  assign clr_evt  = wr_clr & wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '1;
      snap_q <= '0;
      ovf_q  <= '0;
      en_q   <= 1'b0;
      st_q   <= 1'b0;
      msk_q  <= 1'b0;
    end else begin
      if (wr_cfg) en_q <= wdata[0];
      if (wr_rld) rld_q <= wdata;
      if (wr_msk) msk_q <= wdata[0];
      if (load_evt)      cnt_q <= rld_q;
      else if (step_evt) cnt_q <= step_count(cnt_q, rld_q);
      if (wrap_evt) ovf_q <= bump(ovf_q);
      if (rd_ovf) snap_q <= cnt_q;
      if (wrap_evt)     st_q <= 1'b1;
      else if (clr_evt) st_q <= 1'b0;
    end
  end

  assign run_bit  = en_q;
  assign rld_val  = rld_q;
  assign snap_val = snap_q;
  assign ovf_val  = ovf_q;
  assign flag     = st_q;
  assign mask     = msk_q;
  assign irq_req  = st_q & msk_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !load_evt) |=> $stable(cnt_q));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt_q == $past(rld_q)));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == $past(rld_q)) && (ovf_q == $past(ovf_q) + 1'b1));
  a_r5_tally_still: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(ovf_q));
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ovf |=> (snap_q == $past(cnt_q)));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> st_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !wrap_evt) |=> !st_q);
endmodule

// File: rtl/qdt_irq_merge.sv
module qdt_irq_merge #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic           irq
);
  logic irq_q;
  logic any_req;
  assign any_req = |req;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_req;
  end
  assign irq = irq_q;

  a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(any_req)));
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> !irq);
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import qdt_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned AW     = 8,
  parameter logic [31:0] REV_ID = 32'h0001_0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int unsigned CH_END = CH_BASE + CH_STRIDE * NCH;
  localparam int unsigned SHIFT  = $clog2(CH_STRIDE);
  localparam int unsigned CIW    = (NCH > 1) ? $clog2(NCH) : 1;

  logic          glb_q;
  logic          in_ch, hit;
  logic [AW-1:0] rel;
  logic [CIW-1:0] ch_idx;
  logic [OFS_W-1:0] ofs;
  logic [DW-1:0] rd_nxt, rdata_q;

  assign in_ch  = (addr >= AW'(CH_BASE)) && ({1'b0, addr} < (AW+1)'(CH_END));
  assign rel    = addr - AW'(CH_BASE);
  assign ch_idx = rel[SHIFT +: CIW];
  assign ofs    = rel[OFS_W-1:0];

  logic          c_run  [NCH];
  logic [DW-1:0] c_rld  [NCH];
  logic [DW-1:0] c_snap [NCH];
  logic [DW-1:0] c_ovf  [NCH];
  logic          c_flag [NCH];
  logic          c_mask [NCH];
  logic [NCH-1:0] c_req;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = in_ch && (ch_idx == CIW'(i));
    qdt_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .glb_run (glb_q),
      .tick    (tick),
      .wr_cfg  (wr_en && sel && ofs == OFS_CFG),
      .wr_rld  (wr_en && sel && ofs == OFS_RLD),
      .wr_clr  (wr_en && sel && ofs == OFS_CLR),
      .wr_msk  (wr_en && sel && ofs == OFS_MASK),
      .wdata   (wdata),
      .rd_ovf  (rd_en && sel && ofs == OFS_OVF),
      .run_bit (c_run[i]),
      .rld_val (c_rld[i]),
      .snap_val(c_snap[i]),
      .ovf_val (c_ovf[i]),
      .flag    (c_flag[i]),
      .mask    (c_mask[i]),
      .irq_req (c_req[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) glb_q <= 1'b0;
    else if (wr_en && addr == AW'(CTRL_ADDR)) glb_q <= wdata[0];
  end

  always_comb begin
    rd_nxt = '0;
    hit    = 1'b0;
    if (addr == AW'(CTRL_ADDR)) begin
      hit    = 1'b1;
      rd_nxt = {31'b0, glb_q};
    end else if (addr == AW'(REV_ADDR)) begin
      hit    = 1'b1;
      rd_nxt = REV_ID;
    end else if (in_ch) begin
      hit = 1'b1;
      case (ofs)
        OFS_CFG:  rd_nxt = {31'b0, c_run[ch_idx]};
        OFS_RLD:  rd_nxt = c_rld[ch_idx];
        OFS_CNT:  rd_nxt = c_snap[ch_idx];
        OFS_OVF:  rd_nxt = c_ovf[ch_idx];
        OFS_STAT: rd_nxt = {31'b0, c_flag[ch_idx]};
        OFS_MASK: rd_nxt = {31'b0, c_mask[ch_idx]};
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end
  assign rdata = rdata_q;

  qdt_irq_merge #(.NCH(NCH)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (c_req),
    .irq  (irq)
  );

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0));
  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  a_r9_rev_const: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(REV_ADDR)) |=> (rdata == REV_ID));
endmodule

// File: tb/quad_down_timer_bench.sv
module quad_down_timer_bench;
  localparam logic [31:0] REV = 32'h0001_0003;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_vec = 0, n_bad = 0;

  quad_down_timer u_quad_down_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  function automatic logic [7:0] cb(input int c, input int o);
    return 8'(32'h20 + 32'h20 * c + o);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, a0, base [4];
    int rl [4];
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    br(8'h00, v); chk("R1 ctrl", v, 0);
    br(8'h10, v); chk("R2 rev", v, REV);
    for (int c = 0; c < 4; c++) begin
      br(cb(c, 'h00), v); chk("R1 cfg", v, 0);
      br(cb(c, 'h04), v); chk("R1 reload", v, 32'hFFFF_FFFF);
      br(cb(c, 'h0C), v); chk("R1 tally", v, 0);
      br(cb(c, 'h08), v); chk("R1 count", v, 0);
      br(cb(c, 'h10), v); chk("R1 flag", v, 0);
      br(cb(c, 'h18), v); chk("R1 mask", v, 0);
    end

    // R2 unmapped and write-only addresses read zero
    bw(cb(1, 'h04), 32'hDEAD_BEEF);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] ua;
      case (i)
        0: ua = 8'h04; 1: ua = 8'h0C; 2: ua = 8'h14; 3: ua = 8'h1C;
        4: ua = cb(0, 'h1C); 5: ua = cb(3, 'h14); 6: ua = 8'hA0;
        7: ua = 8'hC4; 8: ua = cb(1, 'h05); default: ua = 8'hFF;
      endcase
      br(ua, v); chk("R2 unmapped", v, 0);
    end
    br(cb(1, 'h04), v); chk("R2 reload readback", v, 32'hDEAD_BEEF);

    // R3 R4 R5 R10 sweep: all channels, different reloads, many tick counts
    for (int k = 0; k < 3; k++) begin
      for (int t = 0; t < 12; t++) begin
        bw(8'h00, 0);
        for (int c = 0; c < 4; c++) begin
          rl[c] = c + 3 * k;
          bw(cb(c, 'h00), 0);
          bw(cb(c, 'h04), 32'(rl[c]));
          bw(cb(c, 'h00), 1);
          br(cb(c, 'h0C), base[c]);
        end
        bw(8'h00, 1);
        pulse(t);
        bw(8'h00, 0);
        for (int c = 0; c < 4; c++) begin
          br(cb(c, 'h0C), v);
          chk("R5 R10 tally", v, base[c] + 32'(t / (rl[c] + 1)));
          br(cb(c, 'h08), v);
          chk("R3 R4 R5 count", v, 32'(rl[c] - (t % (rl[c] + 1))));
        end
      end
    end

    // R3 block run off: no counting
    for (int c = 0; c < 4; c++) bw(cb(c, 'h00), 0);
    bw(cb(0, 'h04), 7); bw(cb(0, 'h00), 1);
    pulse(5);
    br(cb(0, 'h0C), v); br(cb(0, 'h08), v); chk("R3 block off", v, 7);
    // R3 channel run off: no counting
    bw(8'h00, 1); bw(cb(0, 'h00), 0);
    pulse(3);
    br(cb(0, 'h0C), v); br(cb(0, 'h08), v); chk("R3 channel off", v, 7);

    // R6 capture ordering
    bw(cb(0, 'h04), 100); bw(cb(0, 'h00), 1);
    br(cb(0, 'h0C), a0);
    pulse(4);
    br(cb(0, 'h08), v); chk("R6 stale capture", v, 100);
    br(cb(0, 'h0C), v); chk("R6 tally", v, a0);
    br(cb(0, 'h08), v); chk("R6 fresh capture", v, 96);

    // R9 read-only writes ignored
    bw(8'h00, 0);
    bw(cb(0, 'h14), 1);
    bw(cb(0, 'h08), 32'h55);
    bw(cb(0, 'h0C), 32'h1234);
    bw(cb(0, 'h10), 1);
    bw(8'h10, 32'hFFFF_FFFF);
    br(cb(0, 'h0C), v); chk("R9 tally", v, a0);
    br(cb(0, 'h08), v); chk("R9 count", v, 96);
    br(cb(0, 'h10), v); chk("R9 flag", v, 0);
    br(8'h10, v); chk("R9 rev", v, REV);

    // R7 R8 R10 flag, mask and interrupt per channel
    for (int c = 0; c < 4; c++) begin
      bw(8'h00, 0);
      for (int d = 0; d < 4; d++) begin
        bw(cb(d, 'h00), 0); bw(cb(d, 'h14), 1); bw(cb(d, 'h18), 0);
      end
      idle(2); chk("R8 idle", {31'b0, irq}, 0);
      bw(cb(c, 'h04), 0); bw(cb(c, 'h00), 1); bw(8'h00, 1);
      pulse(1);
      bw(8'h00, 0);
      for (int d = 0; d < 4; d++) begin
        br(cb(d, 'h10), v); chk("R7 R10 flag", v, (d == c) ? 1 : 0);
      end
      idle(2); chk("R8 masked off", {31'b0, irq}, 0);
      bw(cb(c, 'h18), 1);
      idle(1); chk("R8 unmasked", {31'b0, irq}, 1);
      br(cb(c, 'h18), v); chk("R8 mask readback", v, 1);
      bw(cb(c, 'h14), 1);
      idle(1); chk("R8 cleared", {31'b0, irq}, 0);
      br(cb(c, 'h10), v); chk("R7 clear", v, 0);
      bw(cb(c, 'h18), 0);
    end

    // R7 wrap and clear in the same cycle: set wins
    bw(cb(3, 'h00), 0); bw(cb(3, 'h04), 0); bw(cb(3, 'h00), 1); bw(8'h00, 1);
    @(negedge clk); tick = 1'b1; addr = cb(3, 'h14); wdata = 1; wr_en = 1'b1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    bw(8'h00, 0);
    br(cb(3, 'h10), v); chk("R7 set wins", v, 1);

    summary();
    $finish;
  end
endmodule